// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block puts a flash-style command interface in front of an on-chip byte array. Software talks to it over a simple single-cycle request bus: a write is either a command byte, an argument (confirm code, word count) or program data, depending on which step of a multi-write sequence the block has reached. The block tracks the active command, the step index and an 8-bit status byte. Depending on the active command, a read returns array bytes, the status byte, an identifier or a fixed query table entry.

Accesses are 1, 2 or 4 bytes wide, in little or big byte order. The byte order applies to array data only. Status, identifier and query replies are spread over every device-width lane of the access. A read-only input blocks every change to the array and records an error in the status byte. Program and erase complete at once: there is no busy time, no suspend and no real lock enforcement.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the status byte, the active command and the step index are all zero, and every array byte reads 0xFF.
- R2: In array mode a read returns the bytes at `addr`, `addr+1` and so on, wrapping modulo the array size. The access width is 1 byte for size code 0, 2 bytes for code 1 and 4 bytes for codes 2 and 3. With little byte order, byte `addr+i` goes to bits `8i+7:8i`. With big byte order, the byte at `addr` is the most significant byte of the access. Bits above the access width read zero. Read data appears on the clock after the request and holds until the next read.
- R3: At step 0, the command bytes 0x00, 0xF0 and 0xFF select array mode.
- R4: Command 0x10 or 0x40 arms a program. The next write stores its data at its address with its width and byte order, then sets status bit 7 (ready) and returns to step 0. The command stays active, so reads return status.
- R5: Command 0x20 erases the whole sector holding the address, sets ready and waits for an argument. Sectors are aligned blocks of SECTOR_BYTES bytes, and an erased byte reads 0xFF. An argument of 0xD0 sets ready and ends the sequence with status reads. An argument of 0xFF selects array mode.
- R6: Command 0x50 clears the whole status byte and selects array mode.
- R7: Command 0x70 or 0x90 becomes active without leaving step 0. While the active command is 0x10, 0x20, 0x40, 0x50, 0x60, 0x70 or 0xE8, a read puts the status byte, zero-extended to the device width, into every device-width lane of the access.
- R8: In identifier mode (0x90), a read uses lane index (addr >> log2(DEV_BYTES)). Index 0 returns MANUF_ID, index 1 returns DEVICE_ID and any other index returns 0. The result is truncated to the device width and repeated per lane.
- R9: Command 0x98 enters query mode, and only a later 0xFF leaves it. Reads use the same lane index as R8 and return: 0x10→0x51, 0x11→0x52, 0x12→0x59, 0x13→0x01, 0x27→ADDR_W, 0x2C→0x01, 0x2D→(array bytes/SECTOR_BYTES − 1), any other index→0x00.
- R10: Command 0xE8 sets ready. The next write gives a word count, masked to DEV_BYTES bytes. Count+1 data writes follow, each stored like a program and each setting ready. The next write of 0xD0 then sets ready and ends the sequence.
- R11: After command 0x60, an argument of 0xD0 or 0x01 sets ready and ends at step 0 with status reads. Any other argument selects array mode.
- R12: While read_only is high, a program or buffered data write stores nothing and sets status bit 4, and an erase changes nothing and sets status bit 5. Error bits stay set until command 0x50.
- R13: An unknown command byte at step 0, or a wrong argument in the erase or buffered-confirm step, selects array mode with nothing pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access width code: 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| req_big_end | input | 1 | Byte order of array data, 1 = big |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data, command byte in bits 7:0 |
| read_only | input | 1 | Blocks array changes, flags status errors |
| rd_data | output | 32 | Read reply, valid the clock after a read |

## Verification
The bench builds the block with a 128-byte array, 32-byte sectors and a 2-byte device width. This makes status and identifier replies two-lane patterns with a zero upper byte in each lane, so replication mistakes show up in the data. With a 16-bit count mask, a count write with bit 16 set must still give a short burst. Four sectors mean that an erase next to a sector boundary shows at once whether neighbouring data survived. Directed sequences cover each command's confirm and abort paths. These are followed by random command, data and read traffic that is checked against a bench model.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [1:0] {
        CYC_IDLE = 2'd0,
        CYC_ARG  = 2'd1,
        CYC_DATA = 2'd2,
        CYC_CONF = 2'd3
    } cyc_e;

    localparam logic [7:0] OP_PROG_A  = 8'h10;
    localparam logic [7:0] OP_ERASE   = 8'h20;
    localparam logic [7:0] OP_ERASE_B = 8'h28;
    localparam logic [7:0] OP_PROG_B  = 8'h40;
    localparam logic [7:0] OP_CLRSTS  = 8'h50;
    localparam logic [7:0] OP_LOCK    = 8'h60;
    localparam logic [7:0] OP_RDSTS   = 8'h70;
    localparam logic [7:0] OP_RDID    = 8'h90;
    localparam logic [7:0] OP_QUERY   = 8'h98;
    localparam logic [7:0] OP_BUF     = 8'hE8;
    localparam logic [7:0] OP_CONFIRM = 8'hD0;
    localparam logic [7:0] OP_LOCKALT = 8'h01;
    localparam logic [7:0] OP_ARRAY   = 8'hFF;

    localparam logic [7:0] STS_READY    = 8'h80;
    localparam logic [7:0] STS_ERASEERR = 8'h20;
    localparam logic [7:0] STS_PROGERR  = 8'h10;

    function automatic logic [2:0] size_bytes(input logic [1:0] code);
        case (code)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic is_prog_op(input logic [7:0] c);
        return (c == OP_PROG_A) || (c == OP_PROG_B);
    endfunction

    function automatic logic is_status_op(input logic [7:0] c);
        return (c == OP_PROG_A) || (c == OP_ERASE) || (c == OP_ERASE_B) ||
               (c == OP_PROG_B) || (c == OP_CLRSTS) || (c == OP_LOCK) ||
               (c == OP_RDSTS) || (c == OP_BUF);
    endfunction

    // Repeat a device-width value over every lane inside the access width.
    function automatic logic [31:0] lane_fill(input logic [31:0] v,
                                              input logic [2:0] n,
                                              input int devb);
        logic [31:0] r;
        r = '0;
        for (int b = 0; b < 4; b++) begin
            if (b < int'(n)) r[8*b +: 8] = v[8*(b % devb) +: 8];
        end
        return r;
    endfunction

    function automatic logic [7:0] query_byte(input logic [7:0] idx,
                                              input int aw,
                                              input int nsect);
        case (idx)
            8'h10:   return 8'h51;
            8'h11:   return 8'h52;
            8'h12:   return 8'h59;
            8'h13:   return 8'h01;
            8'h27:   return 8'(aw);
            8'h2C:   return 8'h01;
            8'h2D:   return 8'(nsect - 1);
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
    import flash_seq_pkg::*;
#(
    parameter int DEV_BYTES = 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_stb,
    input  logic [8*DEV_BYTES-1:0] wr_data,
    input  logic                   read_only,
    output logic [7:0]             cmd_o,
    output cyc_e                   cyc_o,
    output logic [7:0]             status_o,
    output logic                   prog_o,
    output logic                   erase_o
);
    localparam int CNT_W = 8 * DEV_BYTES;

    logic [7:0]       op;
    logic [CNT_W-1:0] cnt_q;
    logic [7:0]       perr;

    assign op   = wr_data[7:0];
    assign perr = read_only ? STS_PROGERR : 8'h00;

    always_comb begin
        prog_o  = wr_stb && !read_only &&
                  (((cyc_o == CYC_ARG) && is_prog_op(cmd_o)) ||
                   ((cyc_o == CYC_DATA) && (cmd_o == OP_BUF)));
        erase_o = wr_stb && !read_only && (cyc_o == CYC_IDLE) && (op == OP_ERASE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_o    <= 8'h00;
            cyc_o    <= CYC_IDLE;
            status_o <= 8'h00;
            cnt_q    <= '0;
        end else if (wr_stb) begin
            case (cyc_o)
                CYC_IDLE: begin
                    case (op)
                        OP_PROG_A, OP_PROG_B, OP_LOCK, OP_QUERY: begin
                            cmd_o <= op;
                            cyc_o <= CYC_ARG;
                        end
                        OP_ERASE: begin
                            cmd_o    <= op;
                            cyc_o    <= CYC_ARG;
                            status_o <= status_o | STS_READY |
                                        (read_only ? STS_ERASEERR : 8'h00);
                        end
                        OP_BUF: begin
                            cmd_o    <= op;
                            cyc_o    <= CYC_ARG;
                            status_o <= status_o | STS_READY;
                        end
                        OP_CLRSTS: begin
                            status_o <= 8'h00;
                            cmd_o    <= 8'h00;
                        end
                        OP_RDSTS, OP_RDID: cmd_o <= op;
                        default:           cmd_o <= 8'h00;
                    endcase
                end
                CYC_ARG: begin
                    if (is_prog_op(cmd_o)) begin
                        status_o <= status_o | STS_READY | perr;
                        cyc_o    <= CYC_IDLE;
                    end else if (cmd_o == OP_BUF) begin
                        cnt_q <= wr_data;
                        cyc_o <= CYC_DATA;
                    end else if (cmd_o == OP_QUERY) begin
                        if (op == OP_ARRAY) begin
                            cmd_o <= 8'h00;
                            cyc_o <= CYC_IDLE;
                        end
                    end else if ((cmd_o == OP_ERASE && op == OP_CONFIRM) ||
                                 (cmd_o == OP_LOCK &&
                                  (op == OP_CONFIRM || op == OP_LOCKALT))) begin
                        status_o <= status_o | STS_READY;
                        cyc_o    <= CYC_IDLE;
                    end else begin
                        cmd_o <= 8'h00;
                        cyc_o <= CYC_IDLE;
                    end
                end
                CYC_DATA: begin
                    if (cmd_o == OP_BUF) begin
                        status_o <= status_o | STS_READY | perr;
                        if (cnt_q == '0) cyc_o <= CYC_CONF;
                        cnt_q <= cnt_q - 1'b1;
                    end else begin
                        cmd_o <= 8'h00;
                        cyc_o <= CYC_IDLE;
                    end
                end
                default: begin
                    if (cmd_o == OP_BUF && op == OP_CONFIRM) begin
                        status_o <= status_o | STS_READY;
                    end else begin
                        cmd_o <= 8'h00;
                    end
                    cyc_o <= CYC_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/flash_byte_array.sv
module flash_byte_array #(
    parameter int ADDR_W       = 7,
    parameter int SECTOR_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prog,
    input  logic              erase,
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        nbytes,
    input  logic              big_end,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata
);
    localparam int DEPTH   = 1 << ADDR_W;
    localparam int SECT_LG = $clog2(SECTOR_BYTES);

    logic [7:0] mem [DEPTH];
    logic [7:0] wbyte [4];

    always_comb begin
        rdata = '0;
        for (int b = 0; b < 4; b++) begin
            wbyte[b] = 8'h00;
            if (b < int'(nbytes)) begin
                if (big_end) begin
                    wbyte[b] = wdata[8*(int'(nbytes) - 1 - b) +: 8];
                    rdata[8*(int'(nbytes) - 1 - b) +: 8] = mem[addr + ADDR_W'(b)];
                end else begin
                    wbyte[b] = wdata[8*b +: 8];
                    rdata[8*b +: 8] = mem[addr + ADDR_W'(b)];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (erase) begin
            for (int i = 0; i < DEPTH; i++) begin
                if ((ADDR_W'(i) >> SECT_LG) == (addr >> SECT_LG)) mem[i] <= 8'hFF;
            end
        end else if (prog) begin
            for (int b = 0; b < 4; b++) begin
                if (b < int'(nbytes)) mem[addr + ADDR_W'(b)] <= wbyte[b];
            end
        end
    end
endmodule

// File: rtl/flash_rd_steer.sv
module flash_rd_steer
    import flash_seq_pkg::*;
#(
    parameter int          ADDR_W       = 7,
    parameter int          SECTOR_BYTES = 32,
    parameter int          DEV_BYTES    = 1,
    parameter logic [15:0] MANUF_ID     = 16'h0089,
    parameter logic [15:0] DEVICE_ID    = 16'h0018
) (
    input  logic [7:0]        cmd,
    input  logic [7:0]        status,
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        nbytes,
    input  logic [31:0]       arr_data,
    output logic [31:0]       rdata
);
    localparam int DEV_LG = $clog2(DEV_BYTES);
    localparam int NSECT  = (1 << ADDR_W) / SECTOR_BYTES;

    logic [ADDR_W-1:0] lane_addr;
    logic [7:0]        idx;
    logic [31:0]       id_val;

    assign lane_addr = addr >> DEV_LG;
    assign idx       = 8'(lane_addr);

    always_comb begin
        case (idx)
            8'h00:   id_val = 32'(MANUF_ID);
            8'h01:   id_val = 32'(DEVICE_ID);
            default: id_val = 32'h0;
        endcase
        if (is_status_op(cmd))
            rdata = lane_fill(32'(status), nbytes, DEV_BYTES);
        else if (cmd == OP_RDID)
            rdata = lane_fill(id_val, nbytes, DEV_BYTES);
        else if (cmd == OP_QUERY)
            rdata = lane_fill(32'(query_byte(idx, ADDR_W, NSECT)), nbytes, DEV_BYTES);
        else
            rdata = arr_data;
    end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_seq_pkg::*;
#(
    parameter int          ADDR_W       = 7,
    parameter int          SECTOR_BYTES = 32,
    parameter int          DEV_BYTES    = 1,
    parameter logic [15:0] MANUF_ID     = 16'h0089,
    parameter logic [15:0] DEVICE_ID    = 16'h0018
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic              req_big_end,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    input  logic              read_only,
    output logic [31:0]       rd_data
);
    logic [7:0]  cmd_q;
    cyc_e        cyc_q;
    logic [7:0]  status_q;
    logic        prog, erase;
    logic [2:0]  nbytes;
    logic [31:0] arr_data, steer_data;

    assign nbytes = size_bytes(req_size);

    flash_cmd_fsm #(.DEV_BYTES(DEV_BYTES)) i_fsm (
        .clk(clk), .rst(rst),
        .wr_stb(req_valid && req_write),
        .wr_data(req_wdata[8*DEV_BYTES-1:0]),
        .read_only(read_only),
        .cmd_o(cmd_q), .cyc_o(cyc_q), .status_o(status_q),
        .prog_o(prog), .erase_o(erase)
    );

    flash_byte_array #(.ADDR_W(ADDR_W), .SECTOR_BYTES(SECTOR_BYTES)) i_array (
        .clk(clk), .rst(rst), .prog(prog), .erase(erase),
        .addr(req_addr), .nbytes(nbytes), .big_end(req_big_end),
        .wdata(req_wdata), .rdata(arr_data)
    );

    flash_rd_steer #(
        .ADDR_W(ADDR_W), .SECTOR_BYTES(SECTOR_BYTES), .DEV_BYTES(DEV_BYTES),
        .MANUF_ID(MANUF_ID), .DEVICE_ID(DEVICE_ID)
    ) i_steer (
        .cmd(cmd_q), .status(status_q), .addr(req_addr), .nbytes(nbytes),
        .arr_data(arr_data), .rdata(steer_data)
    );

    always_ff @(posedge clk) begin
        if (rst)                         rd_data <= '0;
        else if (req_valid && !req_write) rd_data <= steer_data;
    end
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_write,
    input logic [7:0]  op,
    input logic        read_only,
    input logic [31:0] rd_data,
    input logic [7:0]  cmd,
    input logic [1:0]  cyc,
    input logic [7:0]  status
);
    logic wr;
    assign wr = req_valid && req_write;

    // R2
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && !req_write) |=> $stable(rd_data));

    // R3
    array_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && cyc == 2'd0 && (op == 8'h00 || op == 8'hF0 || op == 8'hFF))
        |=> (cmd == 8'h00 && cyc == 2'd0));

    // R6
    clr_status_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && cyc == 2'd0 && op == 8'h50) |=> (status == 8'h00 && cmd == 8'h00));

    // R7
    stat_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && cyc == 2'd0 && op == 8'h70) |=> (cmd == 8'h70 && cyc == 2'd0));

    // R12
    ro_prog_err_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && read_only && cyc == 2'd1 && (cmd == 8'h10 || cmd == 8'h40))
        |=> (status[4] && status[7]));

    // R12
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (status[5] && !(wr && cyc == 2'd0 && op == 8'h50)) |=> status[5]);
endmodule

bind flash_cmd_seq flash_cmd_seq_chk i_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .op(req_wdata[7:0]), .read_only(read_only), .rd_data(rd_data),
    .cmd(cmd_q), .cyc(cyc_q), .status(status_q)
);

// File: tb/test_flash_cmd_seq.sv
`timescale 1ns/1ps
module test_flash_cmd_seq;
    localparam int AW = 7, SECT = 32, DEVB = 2;
    localparam logic [15:0] MID = 16'h0089, DID = 16'h0018;

    logic clk = 0, rst = 1;
    logic req_valid = 0, req_write = 0, req_big_end = 0, read_only = 0;
    logic [1:0] req_size = 0;
    logic [AW-1:0] req_addr = 0;
    logic [31:0] req_wdata = 0, rd_data;

    always #2.5 clk = ~clk;

    flash_cmd_seq #(.ADDR_W(AW), .SECTOR_BYTES(SECT), .DEV_BYTES(DEVB),
                    .MANUF_ID(MID), .DEVICE_ID(DID)) i_flash_cmd_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_big_end(req_big_end), .req_addr(req_addr),
        .req_wdata(req_wdata), .read_only(read_only), .rd_data(rd_data));

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    // bench model
    logic [7:0] m_mem [1<<AW];
    logic [7:0] m_st = 0, m_cmd = 0;
    int m_cyc = 0;
    logic [15:0] m_cnt = 0;

    function automatic logic [1:0] enc(input int nb);
        return (nb == 1) ? 2'd0 : (nb == 2) ? 2'd1 : 2'd2;
    endfunction

    function automatic logic [31:0] fill(input logic [15:0] v, input int nb);
        logic [31:0] r = 0;
        for (int b = 0; b < nb; b++) r[8*b +: 8] = (b % 2 == 0) ? v[7:0] : v[15:8];
        return r;
    endfunction

    function automatic logic [7:0] qry(input int i);
        case (i)
            'h10: return 8'h51; 'h11: return 8'h52; 'h12: return 8'h59;
            'h13: return 8'h01; 'h27: return 8'(AW); 'h2C: return 8'h01;
            'h2D: return 8'((1 << AW) / SECT - 1);
            default: return 8'h00;
        endcase
    endfunction

    function automatic bit stat_cmd(input logic [7:0] c);
        return c == 8'h10 || c == 8'h20 || c == 8'h28 || c == 8'h40 ||
               c == 8'h50 || c == 8'h60 || c == 8'h70 || c == 8'hE8;
    endfunction

    function automatic logic [31:0] m_read(input int a, input int nb, input bit be);
        logic [31:0] r = 0;
        int i = a >> 1;
        if (stat_cmd(m_cmd)) return fill({8'h00, m_st}, nb);
        if (m_cmd == 8'h90) return fill(i == 0 ? MID : i == 1 ? DID : 16'h0, nb);
        if (m_cmd == 8'h98) return fill({8'h00, qry(i)}, nb);
        for (int b = 0; b < nb; b++) begin
            if (be) r[8*(nb-1-b) +: 8] = m_mem[(a + b) % (1 << AW)];
            else    r[8*b +: 8]        = m_mem[(a + b) % (1 << AW)];
        end
        return r;
    endfunction

    task automatic m_store(input int a, input logic [31:0] d, input int nb, input bit be);
        for (int b = 0; b < nb; b++)
            m_mem[(a + b) % (1 << AW)] = be ? d[8*(nb-1-b) +: 8] : d[8*b +: 8];
    endtask

    task automatic m_back();
        m_cmd = 0; m_cyc = 0;
    endtask

    task automatic m_write(input int a, input logic [31:0] d, input int nb, input bit be, input bit ro);
        logic [7:0] c = d[7:0];
        case (m_cyc)
            0: case (c)
                8'h10, 8'h40, 8'h60, 8'h98: begin m_cmd = c; m_cyc = 1; end
                8'h20: begin
                    if (ro) m_st |= 8'h20;
                    else for (int i = 0; i < (1 << AW); i++)
                        if (i / SECT == a / SECT) m_mem[i] = 8'hFF;
                    m_st |= 8'h80; m_cmd = c; m_cyc = 1;
                end
                8'h50: begin m_st = 0; m_back(); end
                8'h70, 8'h90: m_cmd = c;
                8'hE8: begin m_st |= 8'h80; m_cmd = c; m_cyc = 1; end
                default: m_back();
            endcase
            1: case (m_cmd)
                8'h10, 8'h40: begin
                    if (ro) m_st |= 8'h10; else m_store(a, d, nb, be);
                    m_st |= 8'h80; m_cyc = 0;
                end
                8'h20: if (c == 8'hD0) begin m_st |= 8'h80; m_cyc = 0; end else m_back();
                8'hE8: begin m_cnt = d[15:0]; m_cyc = 2; end
                8'h60: if (c == 8'hD0 || c == 8'h01) begin m_st |= 8'h80; m_cyc = 0; end
                       else m_back();
                8'h98: if (c == 8'hFF) m_back();
                default: m_back();
            endcase
            2: begin
                if (ro) m_st |= 8'h10; else m_store(a, d, nb, be);
                m_st |= 8'h80;
                if (m_cnt == 0) m_cyc = 3;
                m_cnt = m_cnt - 1;
            end
            default: if (c == 8'hD0) begin m_st |= 8'h80; m_cyc = 0; end else m_back();
        endcase
    endtask

    task automatic wr(input int a, input logic [31:0] d, input int nb = 1,
                      input bit be = 0, input bit ro = 0);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = AW'(a); req_wdata = d;
        req_size = enc(nb); req_big_end = be; read_only = ro;
        @(negedge clk);
        req_valid = 0; req_write = 0; read_only = 0;
        m_write(a, d, nb, be, ro);
    endtask

    task automatic rd(input int a, input int nb, input bit be, output logic [31:0] v);
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = AW'(a);
        req_size = enc(nb); req_big_end = be;
        @(negedge clk);
        req_valid = 0;
        v = rd_data;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // directed read against a literal value, model kept as a cross-check
    task automatic rd_exp(input string tag, input int a, input int nb, input bit be,
                          input logic [31:0] exp);
        logic [31:0] v;
        rd(a, nb, be, v);
        check(tag, v, exp);
    endtask

    task automatic rd_model(input string tag, input int a, input int nb, input bit be);
        logic [31:0] v;
        rd(a, nb, be, v);
        check(tag, v, m_read(a, nb, be));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < (1 << AW); i++) m_mem[i] = 8'hFF;
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state: erased array, status zero
        rd_exp("R1 erased array", 0, 4, 0, 32'hFFFF_FFFF);
        wr(0, 8'h70);
        rd_exp("R1 status zero", 0, 4, 0, 32'h0);
        wr(0, 8'hFF);

        // R4 program, R7 status lanes, R2 byte order
        wr(0, 8'h40);
        wr(4, 32'h1122_3344, 4, 0);
        rd_exp("R4 R7 status after program", 0, 4, 0, 32'h0080_0080);
        wr(0, 8'hFF);
        rd_exp("R4 stored word", 4, 4, 0, 32'h1122_3344);
        rd_exp("R2 big-endian read", 4, 4, 1, 32'h4433_2211);
        rd_exp("R2 half little", 5, 2, 0, 32'h0000_2233);
        rd_exp("R2 half big", 5, 2, 1, 32'h0000_3322);
        wr(0, 8'h10);
        wr(8, 32'hA1B2_C3D4, 4, 1);
        wr(0, 8'hF0);
        rd_exp("R4 big-endian program", 8, 1, 0, 32'h0000_00A1);
        rd_exp("R2 wrap", 127, 2, 0, 32'h0000_FFFF);

        // R12 read-only program
        wr(0, 8'h10);
        wr(12, 32'h55, 1, 0, 1);
        rd_exp("R12 program error", 0, 2, 0, 32'h0000_0090);
        wr(0, 8'hFF);
        rd_exp("R12 not stored", 12, 1, 0, 32'h0000_00FF);

        // R6 clear status
        wr(0, 8'h50);
        rd_exp("R6 array mode after clear", 12, 1, 0, 32'h0000_00FF);
        wr(0, 8'h70);
        rd_exp("R6 status cleared", 0, 4, 0, 32'h0);

        // R5 erase
        wr(0, 8'h40); wr(32, 8'h77);
        wr(0, 8'h40); wr(63, 8'h78);
        wr(0, 8'h40); wr(64, 8'h79);
        wr(0, 8'h50);
        wr(37, 8'h20);
        rd_exp("R5 ready after erase", 0, 1, 0, 32'h80);
        wr(37, 8'hD0);
        rd_exp("R5 status after confirm", 0, 1, 0, 32'h80);
        wr(0, 8'hFF);
        rd_exp("R5 sector start erased", 32, 1, 0, 32'hFF);
        rd_exp("R5 sector end erased", 63, 1, 0, 32'hFF);
        rd_exp("R5 next sector kept", 64, 1, 0, 32'h79);
        wr(100, 8'h20);
        wr(100, 8'h33);
        rd_exp("R13 bad erase argument", 64, 1, 0, 32'h79);
        wr(64, 8'h20);
        wr(64, 8'hFF);
        rd_exp("R5 erase abort reads array", 64, 1, 0, 32'hFF);
        wr(0, 8'h40); wr(64, 8'h79);
        wr(0, 8'h50);
        wr(64, 8'h20, 1, 0, 1);
        rd_exp("R12 erase error", 0, 1, 0, 32'hA0);
        wr(0, 8'hFF);
        rd_exp("R12 sector kept", 64, 1, 0, 32'h79);
        wr(0, 8'h50);

        // R8 identifier
        wr(0, 8'h90);
        rd_exp("R8 manufacturer lanes", 0, 4, 0, 32'h0089_0089);
        rd_exp("R8 device id", 2, 2, 0, 32'h0000_0018);
        rd_exp("R8 other index", 4, 2, 0, 32'h0);
        wr(0, 8'hFF);

        // R9 query
        wr(0, 8'h98);
        rd_exp("R9 Q", 32, 1, 0, 32'h51);
        rd_exp("R9 R", 34, 1, 0, 32'h52);
        rd_exp("R9 Y", 36, 2, 0, 32'h0059);
        rd_exp("R9 size entry", 78, 1, 0, 32'h07);
        rd_exp("R9 sector count", 90, 1, 0, 32'h03);
        wr(0, 8'h00);
        rd_exp("R9 stays in query", 32, 1, 0, 32'h51);
        wr(0, 8'hFF);
        rd_exp("R9 left query", 32, 1, 0, 32'hFF);

        // R10 buffered write
        wr(0, 8'hE8);
        rd_exp("R10 ready after start", 0, 1, 0, 32'h80);
        wr(0, 32'h0001_0002);
        wr(80, 8'hC1); wr(81, 8'hC2); wr(82, 8'hC3);
        wr(0, 8'hD0);
        rd_exp("R10 status after confirm", 0, 1, 0, 32'h80);
        wr(0, 8'hFF);
        rd_exp("R10 burst stored", 80, 4, 0, 32'hFFC3_C2C1);
        wr(0, 8'hE8);
        wr(0, 32'h0001_0000);
        wr(84, 8'hE1);
        wr(85, 8'hD0);
        wr(0, 8'hFF);
        rd_exp("R10 count masked", 84, 2, 0, 32'h0000_FFE1);
        wr(0, 8'hE8); wr(0, 32'h0); wr(86, 8'hE2);
        wr(0, 8'h33);
        rd_exp("R13 bad buffer confirm", 86, 1, 0, 32'hE2);

        // R11 lock acknowledge
        wr(0, 8'h60); wr(0, 8'h01);
        rd_exp("R11 ack reads status", 0, 1, 0, 32'h80);
        wr(0, 8'h60); wr(0, 8'h77);
        rd_exp("R11 other argument", 80, 1, 0, 32'hC1);
        wr(0, 8'h60); wr(0, 8'hD0);
        rd_exp("R11 confirm reads status", 0, 2, 0, 32'h0080);

        // R13 unknown command
        wr(0, 8'h70);
        wr(0, 8'hAB);
        rd_exp("R13 unknown command", 80, 1, 0, 32'hC1);
        // R3 read-array from status mode
        wr(0, 8'h70);
        wr(0, 8'h00);
        rd_exp("R3 read array code", 80, 1, 0, 32'hC1);

        // random traffic against the model
        for (int it = 0; it < 800; it++) begin
            int a = $urandom % (1 << AW);
            int k = $urandom % 3;
            int nb = (k == 0) ? 1 : (k == 1) ? 2 : 4;
            bit be = $urandom % 2;
            if ($urandom % 10 < 4) begin
                rd_model("R2 R7 random read", a, nb, be);
            end else begin
                logic [7:0] ops [15] = '{8'h00, 8'h10, 8'h20, 8'h40, 8'h50, 8'h60, 8'h70,
                                         8'h90, 8'h98, 8'hE8, 8'hF0, 8'hFF, 8'hD0, 8'h01, 8'h5A};
                logic [31:0] d = $urandom;
                int pick = $urandom % 16;
                if (pick < 15 && m_cyc != 2 && !(m_cyc == 1 && (m_cmd == 8'h10 || m_cmd == 8'h40)))
                    d[7:0] = ops[pick];
                if (m_cyc == 1 && m_cmd == 8'hE8) d = $urandom % 3;
                wr(a, d, nb, be, ($urandom % 8) == 0);
            end
        end

        finish_run();
    end
endmodule